// File: doc/BRIEF.md
# Slot ring writer with in-memory full flags

This block moves a stream of sample words into a circular ring of equal-sized slots in host memory. Each slot opens with one descriptor word. Bit 0 of that word is a full flag, and the word also carries a sequence number. The flag is the only handshake with the consumer. The writer fills a slot with burst writes and waits until memory has acknowledged every burst. Only then does it write the descriptor with the flag set. The consumer reads the slot, then clears the flag to hand the slot back.

Before the writer reuses a slot, it reads that slot's descriptor. While the flag is still set, the writer holds its input stalled and polls the descriptor again at a fixed interval. It never overwrites unread data. A sticky status bit records any stall that lasts longer than a programmable limit. The ring base, slot count, poll interval and stall limit are inputs. They are held steady between resets.

With the default parameters, one beat is 8 bytes, a burst is 16 beats (128 bytes), and a slot holds two payload bursts. A slot is therefore 384 bytes. The descriptor sits at slot offset 0, and the payload sits at offsets 128 and 256.

Top module: `slot_ring_writer`

## Requirements
- R1: Each payload write command has `cmd_beats` = 16 and an address at slot offset 128 or 256. `wr_last` is high exactly on the 16th beat of every burst. A descriptor write is a one-beat command at slot offset 0. A command held by a low `cmd_ready` keeps its address and direction.
- R2: Slot k starts at `cfg_base` + k*384. After slot `cfg_slots`-1, the ring wraps back to slot 0 at `cfg_base`.
- R3: A slot's descriptor write is issued only after both payload bursts of that slot have been issued and acknowledged on `wr_ack`.
- R4: The descriptor word written has bit 0 = 1, and bits [47:32] hold a sequence number. The sequence number is 0 for the first slot after reset and rises by one for each slot filled. All other bits are 0.
- R5: Before filling a slot, the writer issues a one-beat read (`cmd_write` = 0) at the slot's start address. After reset, its first command is this read at `cfg_base`.
- R6: When the returned descriptor has bit 0 set, no write command is issued for that slot. The next read of the same descriptor is accepted `cfg_poll`+2 cycles after the cycle in which the read data is valid.
- R7: `in_ready` is high only while payload beats are being passed and `wr_ready` is high. Each accepted sample appears unchanged in memory, in order. None is lost while the writer is stalled.
- R8: `ovf` becomes 1 when a single stall on a full slot lasts longer than `cfg_timeout` cycles. Once set, it stays 1 until reset. It stays 0 for shorter stalls.
- R9: During reset, `in_ready`, `wr_valid` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | 32 | Byte address of slot 0 |
| cfg_slots | input | 8 | Number of slots in the ring (at least 1) |
| cfg_poll | input | 16 | Idle cycles between descriptor polls |
| cfg_timeout | input | 16 | Stall length above which `ovf` is set |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high with `in_valid` |
| in_data | input | 64 | Sample word |
| cmd_valid | output | 1 | Memory command request |
| cmd_ready | input | 1 | Memory command accepted |
| cmd_write | output | 1 | 1 = write burst, 0 = read |
| cmd_addr | output | 32 | Byte address of the command |
| cmd_beats | output | 5 | Number of beats in the command |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_data | output | 64 | Write beat data |
| wr_last | output | 1 | Final beat of a write command |
| wr_ack | input | 1 | One pulse per completed write command |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data (descriptor word) |
| ovf | output | 1 | Sticky stall-overflow status |

## Verification
The properties assume a well-behaved memory port. It returns exactly one `wr_ack` per accepted write command and never acknowledges a write that was not issued. It returns one read beat per read command. They also assume the configuration inputs change only under reset. The bench's memory model keeps to these rules: it acknowledges each burst a fixed three cycles after its last beat, and it answers each read two cycles after the command. The bench changes configuration only while reset is held, and clears a slot's flag only after that slot's descriptor has landed. Write backpressure is added by pulling `wr_ready` low on a fixed pattern, which also puts the hold rule for samples to the test.

// File: rtl/slot_ring_writer.sv
module slot_ring_writer #(
  parameter int DATA_W          = 64,
  parameter int ADDR_W          = 32,
  parameter int BURST_BYTES     = 128,
  parameter int BURSTS_PER_SLOT = 2,
  parameter int IDX_W           = 8,
  parameter int SEQ_W           = 16,
  parameter int SEQ_LSB         = 32,
  parameter int CNT_W           = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_slots,
  input  logic [CNT_W-1:0]  cfg_poll,
  input  logic [CNT_W-1:0]  cfg_timeout,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [$clog2(BURST_BYTES/(DATA_W/8)+1)-1:0] cmd_beats,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_last,
  input  logic              wr_ack,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              ovf
);
  localparam int BEAT_BYTES  = DATA_W / 8;
  localparam int BURST_BEATS = BURST_BYTES / BEAT_BYTES;
  localparam int SLOT_BYTES  = (BURSTS_PER_SLOT + 1) * BURST_BYTES;
  localparam int BEAT_W      = $clog2(BURST_BEATS + 1);
  localparam int BCNT_W      = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam int BSEL_W      = $clog2(BURSTS_PER_SLOT + 1);
  localparam int ACK_W       = $clog2(BURSTS_PER_SLOT + 2);
  localparam logic [ADDR_W-1:0] BURST_STEP = ADDR_W'(BURST_BYTES);
  localparam logic [ADDR_W-1:0] SLOT_STEP  = ADDR_W'(SLOT_BYTES);

  typedef enum logic [3:0] {
    S_RD_CMD, S_RD_WAIT, S_POLL, S_PL_CMD, S_PL_DATA,
    S_ACK_WAIT, S_DS_CMD, S_DS_DATA, S_DS_ACK
  } state_t;

  state_t             st;
  logic [IDX_W-1:0]   idx;
  logic [ADDR_W-1:0]  slot_addr;
  logic [ADDR_W-1:0]  pl_addr;
  logic [BSEL_W-1:0]  burst;
  logic [BCNT_W-1:0]  beat;
  logic [ACK_W-1:0]   acks;
  logic [SEQ_W-1:0]   seq;
  logic [CNT_W-1:0]   poll_cnt;
  logic [CNT_W-1:0]   stall_cnt;
  logic               stalling;
  logic [DATA_W-1:0]  desc_word;

  wire beat_go   = wr_valid && wr_ready;
  wire last_beat = (beat == BCNT_W'(BURST_BEATS - 1));

  always_comb begin
    desc_word = '0;
    desc_word[0] = 1'b1;
    desc_word[SEQ_LSB +: SEQ_W] = seq;
  end

  assign cmd_valid = (st == S_RD_CMD) || (st == S_PL_CMD) || (st == S_DS_CMD);
  assign cmd_write = (st != S_RD_CMD);
  assign cmd_addr  = (st == S_PL_CMD) ? pl_addr : slot_addr;
  assign cmd_beats = (st == S_PL_CMD) ? BEAT_W'(BURST_BEATS) : BEAT_W'(1);
  assign in_ready  = (st == S_PL_DATA) && wr_ready;
  assign wr_valid  = (st == S_PL_DATA) ? in_valid : (st == S_DS_DATA);
  assign wr_data   = (st == S_DS_DATA) ? desc_word : in_data;
  assign wr_last   = (st == S_DS_DATA) || ((st == S_PL_DATA) && last_beat);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_RD_CMD;
      idx       <= '0;
      slot_addr <= cfg_base;
      pl_addr   <= '0;
      burst     <= '0;
      beat      <= '0;
      acks      <= '0;
      seq       <= '0;
      poll_cnt  <= '0;
      stall_cnt <= '0;
      stalling  <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (wr_ack) acks <= acks + 1'b1;
      if (stalling) begin
        if (stall_cnt != '1) stall_cnt <= stall_cnt + 1'b1;
        if (stall_cnt > cfg_timeout) ovf <= 1'b1;
      end
      unique case (st)
        S_RD_CMD:
          if (cmd_ready) st <= S_RD_WAIT;
        S_RD_WAIT:
          if (rd_valid) begin
            if (rd_data[0]) begin
              st       <= S_POLL;
              poll_cnt <= cfg_poll;
              stalling <= 1'b1;
            end else begin
              st        <= S_PL_CMD;
              pl_addr   <= slot_addr + BURST_STEP;
              burst     <= '0;
              acks      <= '0;
              stalling  <= 1'b0;
              stall_cnt <= '0;
            end
          end
        S_POLL:
          if (poll_cnt == '0) st <= S_RD_CMD;
          else poll_cnt <= poll_cnt - 1'b1;
        S_PL_CMD:
          if (cmd_ready) begin
            st   <= S_PL_DATA;
            beat <= '0;
          end
        S_PL_DATA:
          if (beat_go) begin
            beat <= beat + 1'b1;
            if (last_beat) begin
              if (burst == BSEL_W'(BURSTS_PER_SLOT - 1)) begin
                st <= S_ACK_WAIT;
              end else begin
                st      <= S_PL_CMD;
                burst   <= burst + 1'b1;
                pl_addr <= pl_addr + BURST_STEP;
              end
            end
          end
        S_ACK_WAIT:
          if (acks == ACK_W'(BURSTS_PER_SLOT)) st <= S_DS_CMD;
        S_DS_CMD:
          if (cmd_ready) st <= S_DS_DATA;
        S_DS_DATA:
          if (wr_ready) st <= S_DS_ACK;
        S_DS_ACK:
          if (wr_ack) begin
            st  <= S_RD_CMD;
            seq <= seq + 1'b1;
            if (idx == cfg_slots - 1'b1) begin
              idx       <= '0;
              slot_addr <= cfg_base;
            end else begin
              idx       <= idx + 1'b1;
              slot_addr <= slot_addr + SLOT_STEP;
            end
          end
        default: st <= S_RD_CMD;
      endcase
    end
  end
endmodule

module slot_ring_writer_chk #(
  parameter int DATA_W          = 64,
  parameter int ADDR_W          = 32,
  parameter int BEAT_W          = 5,
  parameter int BURSTS_PER_SLOT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [BEAT_W-1:0] cmd_beats,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ack,
  input logic              ovf
);
  logic [3:0] outst;
  logic [3:0] pl_seen;
  wire wcmd = cmd_valid && cmd_ready && cmd_write;
  wire dcmd = wcmd && (cmd_beats == BEAT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      outst   <= '0;
      pl_seen <= '0;
    end else begin
      outst <= outst + {3'b0, wcmd} - {3'b0, wr_ack};
      if (dcmd) pl_seen <= '0;
      else if (wcmd) pl_seen <= pl_seen + 1'b1;
    end
  end

  a_r7_ready_needs_wr_ready: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> wr_ready);

  a_r7_sample_forwarded: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (wr_valid && wr_data == in_data));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  a_r1_cmd_held: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_write)));

  a_r3_payload_acked: assert property (@(posedge clk) disable iff (rst)
    dcmd |-> (outst == 4'd0 && pl_seen == 4'(BURSTS_PER_SLOT)));
endmodule

bind slot_ring_writer slot_ring_writer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BURSTS_PER_SLOT(BURSTS_PER_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_data(wr_data), .wr_ack(wr_ack), .ovf(ovf)
);

// File: tb/slot_ring_writer_bench.sv
module slot_ring_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_base = BASE;
  logic [7:0]  cfg_slots = 8'd3;
  logic [15:0] cfg_poll = 16'd5;
  logic [15:0] cfg_timeout = 16'd1000;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        cmd_valid, cmd_write;
  logic        cmd_ready = 1'b1;
  logic [31:0] cmd_addr;
  logic [4:0]  cmd_beats;
  logic        wr_valid, wr_last;
  logic        wr_ready = 1'b1;
  logic [63:0] wr_data;
  logic        wr_ack;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_ring_writer u_slot_ring_writer (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_slots(cfg_slots),
    .cfg_poll(cfg_poll), .cfg_timeout(cfg_timeout),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ack(wr_ack), .rd_valid(rd_valid), .rd_data(rd_data), .ovf(ovf)
  );

  // memory model and monitors
  logic [63:0] mem [0:255];
  logic [7:0]  w_ptr, rd_a, clr_word;
  logic [4:0]  w_beats, w_cnt;
  logic [2:0]  ack_sh;
  logic        rd_p, rd_v, bp, clr_req = 1'b0;
  logic [63:0] rd_d;
  int cyc, fmt_err, ord_err, desc_cnt, wcmd_cnt, acc_cnt, rdy_cnt;
  int pl_issued, outst, t_flag, poll_gap;
  logic [31:0] last_desc_addr;
  logic flag_seen;

  assign wr_ack   = ack_sh[2];
  assign rd_valid = rd_v;
  assign rd_data  = rd_d;

  function automatic logic [7:0] widx(input logic [31:0] a);
    logic [31:0] d;
    d = (a - BASE) >> 3;
    return d[7:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      ack_sh <= '0; rd_p <= 1'b0; rd_v <= 1'b0; rd_d <= '0;
      w_ptr <= '0; w_beats <= '0; w_cnt <= '0;
      cyc <= 0; fmt_err <= 0; ord_err <= 0; desc_cnt <= 0; wcmd_cnt <= 0;
      acc_cnt <= 0; rdy_cnt <= 0; pl_issued <= 0; outst <= 0;
      t_flag <= 0; poll_gap <= -1; flag_seen <= 1'b0; last_desc_addr <= '0;
      wr_ready <= 1'b1;
    end else begin
      cyc <= cyc + 1;
      wr_ready <= bp ? (cyc % 3 != 0) : 1'b1;
      ack_sh <= {ack_sh[1:0], 1'b0};
      rd_p <= 1'b0;
      rd_v <= rd_p;
      rd_d <= mem[rd_a];
      if (in_ready) rdy_cnt <= rdy_cnt + 1;
      if (in_valid && in_ready) acc_cnt <= acc_cnt + 1;
      if (rd_v && rd_d[0]) begin t_flag <= cyc; flag_seen <= 1'b1; end
      if (cmd_valid && cmd_ready) begin
        if (!cmd_write) begin
          rd_p <= 1'b1; rd_a <= widx(cmd_addr);
          if (cmd_beats != 5'd1 || (cmd_addr - BASE) % 384 != 0) fmt_err <= fmt_err + 1;
          if (flag_seen) begin poll_gap <= cyc - t_flag; flag_seen <= 1'b0; end
        end else begin
          wcmd_cnt <= wcmd_cnt + 1;
          w_ptr <= widx(cmd_addr); w_beats <= cmd_beats; w_cnt <= '0;
          if (cmd_beats == 5'd1) begin
            desc_cnt <= desc_cnt + 1;
            last_desc_addr <= cmd_addr;
            if (pl_issued != 2 || outst != (wr_ack ? 1 : 0)) ord_err <= ord_err + 1;
            if ((cmd_addr - BASE) % 384 != 0) fmt_err <= fmt_err + 1;
            pl_issued <= 0;
          end else begin
            pl_issued <= pl_issued + 1;
            if (cmd_beats != 5'd16 ||
                ((cmd_addr - BASE) % 384 != 128 && (cmd_addr - BASE) % 384 != 256))
              fmt_err <= fmt_err + 1;
          end
        end
      end
      outst <= outst + ((cmd_valid && cmd_ready && cmd_write) ? 1 : 0) - (wr_ack ? 1 : 0);
      if (wr_valid && wr_ready) begin
        mem[w_ptr] <= wr_data;
        w_ptr <= w_ptr + 1'b1;
        w_cnt <= w_cnt + 1'b1;
        if (wr_last != (w_cnt == w_beats - 1'b1)) fmt_err <= fmt_err + 1;
        if (wr_last) ack_sh[0] <= 1'b1;
      end
      if (clr_req) mem[clr_word][0] <= 1'b0;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sample(input int k);
    return {32'h5A17_0000, 32'(k)};
  endfunction

  function automatic logic [63:0] desc_exp(input int s);
    return {16'h0, 16'(s), 31'h0, 1'b1};
  endfunction

  task automatic push_samples(input int first, input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = sample(first + k);
      if (in_ready) k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_desc(input int n);
    int w = 0;
    while (desc_cnt < n && w < 3000) begin @(negedge clk); w++; end
    repeat (12) @(negedge clk);
  endtask

  task automatic clear_flag(input int slot);
    @(negedge clk);
    clr_req = 1'b1; clr_word = 8'(slot * 48);
    @(negedge clk);
    clr_req = 1'b0;
  endtask

  task automatic check_slot(input int slot, input int first, input int seq, input string req);
    int bad = 0;
    int badi = 0;
    for (int j = 0; j < 32; j++)
      if (mem[slot*48 + 16 + j] !== sample(first + j)) begin bad++; badi = j; end
    check(bad == 0, req, mem[slot*48 + 16 + badi], sample(first + badi));
    check(mem[slot*48] === desc_exp(seq), "R4", mem[slot*48], desc_exp(seq));
  endtask

  task automatic do_reset(input logic [7:0] slots, input logic [15:0] tmo);
    @(negedge clk);
    rst = 1'b1; cfg_slots = slots; cfg_timeout = tmo; bp = 1'b0;
    repeat (3) @(negedge clk);
    check(!in_ready && !wr_valid && !ovf, "R9", {in_ready, wr_valid, ovf}, 0);
    check(cmd_valid && !cmd_write && cmd_addr == BASE && cmd_beats == 5'd1, "R5",
          cmd_addr, BASE);
    rst = 1'b0;
  endtask

  task automatic t_first_slot;
    push_samples(0, 32);
    wait_desc(1);
    check_slot(0, 0, 0, "R7");
    check(fmt_err == 0, "R1", fmt_err, 0);
    check(ord_err == 0, "R3", ord_err, 0);
  endtask

  task automatic t_wrap_backpressure;
    bp = 1'b1;
    push_samples(32, 64);
    wait_desc(3);
    check_slot(1, 32, 1, "R7");
    check_slot(2, 64, 2, "R7");
    clear_flag(0); clear_flag(1); clear_flag(2);
    push_samples(96, 32);
    wait_desc(4);
    bp = 1'b0;
    check_slot(0, 96, 3, "R2");
    check(last_desc_addr == BASE, "R2", last_desc_addr, BASE);
    check(fmt_err == 0 && ord_err == 0, "R3", ord_err, 0);
  endtask

  task automatic t_stall;
    int acc0, rdy0, wc0;
    push_samples(128, 64);
    wait_desc(6);
    fork
      push_samples(192, 32);
      begin
        repeat (4) @(negedge clk);
        acc0 = acc_cnt; rdy0 = rdy_cnt; wc0 = wcmd_cnt;
        repeat (60) @(negedge clk);
        check(acc_cnt == acc0 && rdy_cnt == rdy0, "R7", rdy_cnt - rdy0, 0);
        check(wcmd_cnt == wc0, "R6", wcmd_cnt - wc0, 0);
        check(poll_gap == 7, "R6", poll_gap, 7);
        check(ovf == 1'b0, "R8", ovf, 0);
        clear_flag(0);
      end
    join
    wait_desc(7);
    check_slot(0, 192, 6, "R7");
  endtask

  task automatic t_overflow;
    do_reset(8'd1, 16'd30);
    push_samples(0, 32);
    wait_desc(1);
    check(ovf == 1'b0, "R8", ovf, 0);
    repeat (100) @(negedge clk);
    check(ovf == 1'b1, "R8", ovf, 1);
    clear_flag(0);
    push_samples(500, 32);
    wait_desc(2);
    check_slot(0, 500, 1, "R2");
    check(last_desc_addr == BASE, "R2", last_desc_addr, BASE);
    check(ovf == 1'b1, "R8", ovf, 1);
  endtask

  initial begin
    bp = 1'b0;
    do_reset(8'd3, 16'd1000);
    t_first_slot();
    t_wrap_backpressure();
    t_stall();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule